// File: doc/BRIEF.md
# Inbound/Outbound Queue Messaging Unit

This block is the controller-side end of a host-to-controller request channel. It sits behind a simple 32-bit register bus. The host obtains request handles, posts them for processing and collects completions, all through two queue ports whose behaviour depends on whether the access is a read or a write. A processing agent inside the controller takes posted handles from a pending FIFO and returns results into a completion FIFO. Each result raises a host interrupt until the host acknowledges it.

Three FIFOs hold the traffic. The free-handle FIFO holds offsets into the controller's own memory window. It is filled at reset and refilled when the host hands a controller-memory handle back. The pending FIFO carries posted handles to the agent. The completion FIFO carries the agent's results to the host. A handle with bit 31 set is a tagged host-memory handle, formed as `0x80000000 | (bus_address >> 5)`, which requires 32-byte alignment. Such handles pass through the unit untouched and never enter the free list.

Commands outside the queues travel through two inbound and two outbound message registers. A command written to an inbound message register is complete once the agent writes the same value back to the outbound message register. A doorbell register and an inbound status/mask pair notify the agent. An outbound status/mask pair drives the host interrupt.

Top module: `qmsg_unit`

## Requirements
- R1: After reset, every message register, the doorbell (0x20), both status registers (0x24, 0x30) and both mask registers (0x28, 0x34) read 0. `irq_out` and `irq_in` are low, `agent_req_valid` is low and `agent_cpl_ready` is high.
- R2: A read of offset 0x40 returns the oldest free handle and removes it. After reset the free list holds FREE_DEPTH handles, which come out as FREE_BASE + i*FREE_STRIDE for i = 0, 1, 2, and so on.
- R3: A read of 0x40 while the free list is empty returns 0xFFFFFFFF and changes no state.
- R4: A write to 0x40 posts the written handle into the pending FIFO. The agent receives posted handles in posting order, each unchanged, including tagged handles with bit 31 set.
- R5: Each value accepted from the agent is queued verbatim in the completion FIFO. This includes a context word that the agent returns in place of the handle. A read of 0x44 pops completions in order, and a read while the queue is empty returns 0xFFFFFFFF.
- R6: A write to 0x44 with bit 31 clear appends the written handle to the tail of the free list. A write with bit 31 set leaves the free list unchanged.
- R7: At offset 0x30, outbound status bit 0 is set when a completion is queued and bit 1 is set when the agent writes an outbound message. Writing 1 to a bit clears it. A new event in the same cycle as the clear keeps the bit set.
- R8: `irq_out` is high exactly when some outbound status bit is set and the corresponding bit of the mask at 0x34 is 0.
- R9: Each inbound event sets its own bit of the inbound status register at 0x24: a write to message 0 (0x10) sets bit 0, a write to message 1 (0x14) sets bit 1, a nonzero doorbell write sets bit 2 and a post sets bit 3. The agent clears these bits through `agent_istat_clr`. A doorbell write ORs its bits into the doorbell, and `agent_db_clr` clears doorbell bits. `irq_in` follows the status bits, with the bits set in the mask at 0x28 left out.
- R10: A post while the pending FIFO is full is dropped. `agent_cpl_ready` is low while the completion FIFO is full, so the agent holds its next request.
- R11: Agent writes to outbound message 0 or 1 read back at 0x18 or 0x1C respectively. Host writes to those offsets have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Bus write strobe |
| reg_rd | input | 1 | Bus read strobe; queue-port side effects are applied at the clock edge |
| reg_addr | input | ADDR_W | Byte offset |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid during the cycle in which `reg_rd` is high |
| irq_out | output | 1 | Interrupt to the host |
| irq_in | output | 1 | Interrupt to the processing agent |
| agent_req_valid | output | 1 | Pending FIFO not empty |
| agent_req_handle | output | 32 | Oldest pending handle |
| agent_req_ready | input | 1 | Agent takes the pending handle |
| agent_cpl_valid | input | 1 | Agent offers a completion |
| agent_cpl_data | input | 32 | Completion word |
| agent_cpl_ready | output | 1 | Completion FIFO can accept |
| agent_imsg0 | output | 32 | Inbound message 0 |
| agent_imsg1 | output | 32 | Inbound message 1 |
| agent_doorbell | output | 32 | Doorbell bits |
| agent_db_clr | input | 32 | Doorbell bits to clear |
| agent_istat_clr | input | 4 | Inbound status bits to clear |
| agent_omsg_we | input | 1 | Outbound message write |
| agent_omsg_sel | input | 1 | Selects outbound message 0 or 1 |
| agent_omsg_data | input | 32 | Outbound message value |

## Verification
The bench builds the unit with PEND_DEPTH and CPL_DEPTH of 4 and keeps FREE_DEPTH at its default of 8. With the shallow queues, a dropped post and a completion FIFO that stalls the agent can both be reached with a few bus writes. With the full free list, the bench can drain every reset handle, check the empty-read value and then watch a returned handle come back at the tail. A stub agent in the bench substitutes a context word for tagged handles whose bit 0 is set, so both kinds of completion flow through the same scoreboard.

// File: rtl/qmsg_pkg.sv
// Package: register offsets and constants shared by the messaging unit.
// Assumes a byte-addressed register bus with 32-bit aligned registers.
package qmsg_pkg;
    localparam logic [7:0] OFS_IMSG0 = 8'h10;
    localparam logic [7:0] OFS_IMSG1 = 8'h14;
    localparam logic [7:0] OFS_OMSG0 = 8'h18;
    localparam logic [7:0] OFS_OMSG1 = 8'h1C;
    localparam logic [7:0] OFS_IDB   = 8'h20;
    localparam logic [7:0] OFS_ISTAT = 8'h24;
    localparam logic [7:0] OFS_IMASK = 8'h28;
    localparam logic [7:0] OFS_OSTAT = 8'h30;
    localparam logic [7:0] OFS_OMASK = 8'h34;
    localparam logic [7:0] OFS_INQ   = 8'h40;
    localparam logic [7:0] OFS_OUTQ  = 8'h44;

    localparam logic [31:0] EMPTY_WORD   = 32'hFFFF_FFFF;
    localparam int          HOST_TAG_BIT = 31;

    // inbound status bit positions
    localparam int IN_SRC_N   = 4;
    localparam int IN_B_MSG0  = 0;
    localparam int IN_B_MSG1  = 1;
    localparam int IN_B_DBELL = 2;
    localparam int IN_B_POST  = 3;

    // outbound status bit positions
    localparam int OUT_SRC_N  = 2;
    localparam int OUT_B_CPL  = 0;
    localparam int OUT_B_OMSG = 1;
endpackage

// File: rtl/qmsg_fifo.sv
// Module: synchronous show-ahead FIFO with optional arithmetic preload at reset.
// Assumes: callers never push when full or pop when empty; DEPTH >= 2;
// INIT_CNT <= DEPTH. Preloaded entry i holds INIT_BASE + i*INIT_STEP.
module qmsg_fifo #(
    parameter int                 DEPTH     = 8,
    parameter int                 WIDTH     = 32,
    parameter int                 INIT_CNT  = 0,
    parameter logic [WIDTH-1:0]   INIT_BASE = '0,
    parameter logic [WIDTH-1:0]   INIT_STEP = '0
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          push_i,
    input  logic [WIDTH-1:0]              push_data_i,
    input  logic                          pop_i,
    output logic [WIDTH-1:0]              head_o,
    output logic                          empty_o,
    output logic                          full_o,
    output logic [$clog2(DEPTH+1)-1:0]    count_o
);
    localparam int PTR_W = $clog2(DEPTH);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(DEPTH - 1);
    localparam logic [PTR_W-1:0] INIT_WPTR = PTR_W'(INIT_CNT % DEPTH);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count_q;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == LAST_PTR) ? '0 : p + 1'b1;
    endfunction

    // One storage entry per slot: preload at reset, capture on push.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        localparam logic [WIDTH-1:0] PRELOAD =
            (g < INIT_CNT) ? INIT_BASE + INIT_STEP * WIDTH'(g) : '0;
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= PRELOAD;
            else if (push_i && wr_ptr == PTR_W'(g))
                mem[g] <= push_data_i;
        end
    end

    // Pointer and occupancy bookkeeping.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_ptr  <= '0;
            wr_ptr  <= INIT_WPTR;
            count_q <= CNT_W'(INIT_CNT);
        end else begin
            if (push_i) wr_ptr <= bump(wr_ptr);
            if (pop_i)  rd_ptr <= bump(rd_ptr);
            case ({push_i, pop_i})
                2'b10:   count_q <= count_q + 1'b1;
                2'b01:   count_q <= count_q - 1'b1;
                default: count_q <= count_q;
            endcase
        end
    end

    // Status and head outputs.
    always_comb begin
        head_o  = mem[rd_ptr];
        empty_o = (count_q == '0);
        full_o  = (count_q == CNT_W'(DEPTH));
        count_o = count_q;
    end

    // R10
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        full_o |-> !push_i || pop_i);
    // R3
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pop_i |-> !empty_o);
endmodule

// File: rtl/qmsg_intr.sv
// Module: sticky interrupt status bits with a mask and a combined request.
// Assumes: set_i events win over clr_i in the same cycle; a mask bit of 1
// keeps its source out of irq_o.
module qmsg_intr #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_i,
    input  logic [N-1:0] clr_i,
    input  logic         mask_we_i,
    input  logic [N-1:0] mask_d_i,
    output logic [N-1:0] status_o,
    output logic [N-1:0] mask_o,
    output logic         irq_o
);
    logic [N-1:0] stat_q, mask_q;

    // Sticky status: clear requested bits, then apply new events.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_i) | set_i;
    end

    // Mask register written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_we_i) mask_q <= mask_d_i;
    end

    // Drive status, mask and the combined request.
    always_comb begin
        status_o = stat_q;
        mask_o   = mask_q;
        irq_o    = |(stat_q & ~mask_q);
    end

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_i) |=> ((stat_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/qmsg_unit.sv
// Module: top of the queue messaging unit. Decodes the register bus, routes
// the queue ports to the free, pending and completion FIFOs, holds the
// message and doorbell registers, and raises host and agent interrupts.
// Assumes: at most one of reg_rd/reg_wr per cycle; reg_rdata is combinational
// while reg_rd is high, and any pop takes effect at the following edge.
module qmsg_unit
    import qmsg_pkg::*;
#(
    parameter int          ADDR_W      = 8,
    parameter int          FREE_DEPTH  = 8,
    parameter int          PEND_DEPTH  = 8,
    parameter int          CPL_DEPTH   = 8,
    parameter logic [31:0] FREE_BASE   = 32'h0000_1000,
    parameter logic [31:0] FREE_STRIDE = 32'h0000_0100
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq_out,
    output logic              irq_in,
    output logic              agent_req_valid,
    output logic [31:0]       agent_req_handle,
    input  logic              agent_req_ready,
    input  logic              agent_cpl_valid,
    input  logic [31:0]       agent_cpl_data,
    output logic              agent_cpl_ready,
    output logic [31:0]       agent_imsg0,
    output logic [31:0]       agent_imsg1,
    output logic [31:0]       agent_doorbell,
    input  logic [31:0]       agent_db_clr,
    input  logic [3:0]        agent_istat_clr,
    input  logic              agent_omsg_we,
    input  logic              agent_omsg_sel,
    input  logic [31:0]       agent_omsg_data
);
    localparam int FCNT_W = $clog2(FREE_DEPTH + 1);
    localparam int PCNT_W = $clog2(PEND_DEPTH + 1);
    localparam int CCNT_W = $clog2(CPL_DEPTH + 1);

    // address match helpers
    function automatic logic at(input logic [ADDR_W-1:0] a, input logic [7:0] ofs);
        return a == ADDR_W'(ofs);
    endfunction

    logic [31:0] imsg0_q, imsg1_q, omsg0_q, omsg1_q, dbell_q;
    logic [31:0] free_head, pend_head, cpl_head;
    logic        free_empty, free_full, pend_empty, pend_full, cpl_empty, cpl_full;
    logic [FCNT_W-1:0] free_count;
    logic [PCNT_W-1:0] pend_count;
    logic [CCNT_W-1:0] cpl_count;
    logic        free_pop, free_push, pend_push, pend_pop, cpl_push, cpl_pop;
    logic        wr_imsg0, wr_imsg1, wr_dbell, wr_ostat, wr_imask, wr_omask;
    logic [IN_SRC_N-1:0]  in_set, in_stat, in_mask;
    logic [OUT_SRC_N-1:0] out_set, out_clr, out_stat, out_mask;

    // Bus decode and FIFO handshakes.
    always_comb begin
        wr_imsg0  = reg_wr && at(reg_addr, OFS_IMSG0);
        wr_imsg1  = reg_wr && at(reg_addr, OFS_IMSG1);
        wr_dbell  = reg_wr && at(reg_addr, OFS_IDB);
        wr_ostat  = reg_wr && at(reg_addr, OFS_OSTAT);
        wr_imask  = reg_wr && at(reg_addr, OFS_IMASK);
        wr_omask  = reg_wr && at(reg_addr, OFS_OMASK);
        free_pop  = reg_rd && at(reg_addr, OFS_INQ) && !free_empty;
        free_push = reg_wr && at(reg_addr, OFS_OUTQ) && !reg_wdata[HOST_TAG_BIT] && !free_full;
        pend_push = reg_wr && at(reg_addr, OFS_INQ) && !pend_full;
        pend_pop  = !pend_empty && agent_req_ready;
        cpl_push  = agent_cpl_valid && !cpl_full;
        cpl_pop   = reg_rd && at(reg_addr, OFS_OUTQ) && !cpl_empty;
    end

    qmsg_fifo #(
        .DEPTH(FREE_DEPTH), .WIDTH(32), .INIT_CNT(FREE_DEPTH),
        .INIT_BASE(FREE_BASE), .INIT_STEP(FREE_STRIDE)
    ) u_free (
        .clk, .rst_n, .push_i(free_push), .push_data_i(reg_wdata), .pop_i(free_pop),
        .head_o(free_head), .empty_o(free_empty), .full_o(free_full), .count_o(free_count)
    );

    qmsg_fifo #(
        .DEPTH(PEND_DEPTH), .WIDTH(32), .INIT_CNT(0), .INIT_BASE('0), .INIT_STEP('0)
    ) u_pend (
        .clk, .rst_n, .push_i(pend_push), .push_data_i(reg_wdata), .pop_i(pend_pop),
        .head_o(pend_head), .empty_o(pend_empty), .full_o(pend_full), .count_o(pend_count)
    );

    qmsg_fifo #(
        .DEPTH(CPL_DEPTH), .WIDTH(32), .INIT_CNT(0), .INIT_BASE('0), .INIT_STEP('0)
    ) u_cpl (
        .clk, .rst_n, .push_i(cpl_push), .push_data_i(agent_cpl_data), .pop_i(cpl_pop),
        .head_o(cpl_head), .empty_o(cpl_empty), .full_o(cpl_full), .count_o(cpl_count)
    );

    // Inbound message registers, written by the host.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            imsg0_q <= '0;
            imsg1_q <= '0;
        end else begin
            if (wr_imsg0) imsg0_q <= reg_wdata;
            if (wr_imsg1) imsg1_q <= reg_wdata;
        end
    end

    // Outbound message registers, written only by the agent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            omsg0_q <= '0;
            omsg1_q <= '0;
        end else if (agent_omsg_we) begin
            if (agent_omsg_sel) omsg1_q <= agent_omsg_data;
            else                omsg0_q <= agent_omsg_data;
        end
    end

    // Doorbell: host ORs bits in, agent clears bits.
    always_ff @(posedge clk) begin
        if (!rst_n) dbell_q <= '0;
        else        dbell_q <= (dbell_q & ~agent_db_clr) | (wr_dbell ? reg_wdata : 32'h0);
    end

    // Interrupt event vectors.
    always_comb begin
        in_set                = '0;
        in_set[IN_B_MSG0]     = wr_imsg0;
        in_set[IN_B_MSG1]     = wr_imsg1;
        in_set[IN_B_DBELL]    = wr_dbell && (reg_wdata != 32'h0);
        in_set[IN_B_POST]     = pend_push;
        out_set               = '0;
        out_set[OUT_B_CPL]    = cpl_push;
        out_set[OUT_B_OMSG]   = agent_omsg_we;
        out_clr               = wr_ostat ? reg_wdata[OUT_SRC_N-1:0] : '0;
    end

    qmsg_intr #(.N(IN_SRC_N)) u_in_irq (
        .clk, .rst_n, .set_i(in_set), .clr_i(agent_istat_clr),
        .mask_we_i(wr_imask), .mask_d_i(reg_wdata[IN_SRC_N-1:0]),
        .status_o(in_stat), .mask_o(in_mask), .irq_o(irq_in)
    );

    qmsg_intr #(.N(OUT_SRC_N)) u_out_irq (
        .clk, .rst_n, .set_i(out_set), .clr_i(out_clr),
        .mask_we_i(wr_omask), .mask_d_i(reg_wdata[OUT_SRC_N-1:0]),
        .status_o(out_stat), .mask_o(out_mask), .irq_o(irq_out)
    );

    // Read data multiplexer.
    always_comb begin
        reg_rdata = 32'h0;
        if (reg_rd) begin
            case (8'(reg_addr))
                OFS_IMSG0: reg_rdata = imsg0_q;
                OFS_IMSG1: reg_rdata = imsg1_q;
                OFS_OMSG0: reg_rdata = omsg0_q;
                OFS_OMSG1: reg_rdata = omsg1_q;
                OFS_IDB:   reg_rdata = dbell_q;
                OFS_ISTAT: reg_rdata = 32'(in_stat);
                OFS_IMASK: reg_rdata = 32'(in_mask);
                OFS_OSTAT: reg_rdata = 32'(out_stat);
                OFS_OMASK: reg_rdata = 32'(out_mask);
                OFS_INQ:   reg_rdata = free_empty ? EMPTY_WORD : free_head;
                OFS_OUTQ:  reg_rdata = cpl_empty ? EMPTY_WORD : cpl_head;
                default:   reg_rdata = 32'h0;
            endcase
        end
    end

    // Agent-facing outputs.
    always_comb begin
        agent_req_valid  = !pend_empty;
        agent_req_handle = pend_head;
        agent_cpl_ready  = !cpl_full;
        agent_imsg0      = imsg0_q;
        agent_imsg1      = imsg1_q;
        agent_doorbell   = dbell_q;
    end

    // R3
    empty_inq_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && at(reg_addr, OFS_INQ) && free_count == '0) |-> reg_rdata == EMPTY_WORD);
    // R6
    tagged_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !reg_rd && at(reg_addr, OFS_OUTQ) && reg_wdata[HOST_TAG_BIT])
        |=> $stable(free_count));
    // R5
    cpl_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && at(reg_addr, OFS_OUTQ) && cpl_count != '0 && !agent_cpl_valid)
        |=> cpl_count == $past(cpl_count) - 1'b1);
    // R10
    pend_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_count == PCNT_W'(PEND_DEPTH) && !agent_req_ready) |=> $stable(pend_count));
endmodule

// File: tb/qmsg_unit_test.sv
// Scoreboard bench: the host driver queues expected requests, the stub agent
// checks them and queues expected completions, and host pops compare those.
module qmsg_unit_test;
    import qmsg_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic        irq_out, irq_in;
    logic        agent_req_valid, agent_req_ready = 1'b0;
    logic [31:0] agent_req_handle;
    logic        agent_cpl_valid = 1'b0, agent_cpl_ready;
    logic [31:0] agent_cpl_data = '0;
    logic [31:0] agent_imsg0, agent_imsg1, agent_doorbell;
    logic [31:0] agent_db_clr = '0;
    logic [3:0]  agent_istat_clr = '0;
    logic        agent_omsg_we = 1'b0, agent_omsg_sel = 1'b0;
    logic [31:0] agent_omsg_data = '0;

    int checks = 0, fails = 0;
    logic stub_en = 1'b0;
    logic [31:0] exp_req[$];
    logic [31:0] exp_cpl[$];
    logic [31:0] rd;

    always #2 clk = ~clk;

    qmsg_unit #(.PEND_DEPTH(4), .CPL_DEPTH(4)) uut (.*);

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic host_wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic host_rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk); reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk); reg_rd = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string req);
        logic [31:0] d;
        host_rd(a, d);
        chk(d == exp, req, d, exp);
    endtask

    // driver: post a handle and queue it as an expected request
    task automatic post(input logic [31:0] h);
        exp_req.push_back(h);
        host_wr(OFS_INQ, h);
    endtask

    // scoreboard pop of one completion
    task automatic host_pop(input string req);
        logic [31:0] d, e;
        host_rd(OFS_OUTQ, d);
        if (exp_cpl.size() == 0) chk(1'b0, req, d, EMPTY_WORD);
        else begin
            e = exp_cpl.pop_front();
            chk(d == e, req, d, e);
        end
    endtask

    task automatic agent_iclr(input logic [3:0] m);
        @(negedge clk); agent_istat_clr = m;
        @(negedge clk); agent_istat_clr = '0;
    endtask

    task automatic agent_omsg(input logic s, input logic [31:0] v);
        @(negedge clk); agent_omsg_we = 1'b1; agent_omsg_sel = s; agent_omsg_data = v;
        @(negedge clk); agent_omsg_we = 1'b0;
    endtask

    function automatic logic [31:0] stub_result(input logic [31:0] h);
        return (h[31] && h[0]) ? (32'h5A00_0000 | {16'h0, h[15:0]}) : h;
    endfunction

    // stub agent and request monitor (R4, R5)
    initial begin
        forever begin
            @(negedge clk);
            agent_req_ready = 1'b0;
            agent_cpl_valid = 1'b0;
            if (stub_en && agent_req_valid && agent_cpl_ready) begin
                if (exp_req.size() == 0) chk(1'b0, "R4 unexpected request", agent_req_handle, 32'h0);
                else begin
                    logic [31:0] e;
                    e = exp_req.pop_front();
                    chk(agent_req_handle == e, "R4 request order", agent_req_handle, e);
                end
                exp_cpl.push_back(stub_result(agent_req_handle));
                agent_req_ready = 1'b1;
                agent_cpl_valid = 1'b1;
                agent_cpl_data  = stub_result(agent_req_handle);
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(!irq_out && !irq_in, "R1 irqs low", {30'h0, irq_out, irq_in}, 32'h0);
        chk(!agent_req_valid && agent_cpl_ready, "R1 agent handshake", {30'h0, agent_req_valid, agent_cpl_ready}, 32'h1);
        rd_chk(OFS_OSTAT, 32'h0, "R1 ostat");
        rd_chk(OFS_ISTAT, 32'h0, "R1 istat");
        rd_chk(OFS_IMSG0, 32'h0, "R1 imsg0");
        rd_chk(OFS_IDB,   32'h0, "R1 doorbell");
        rd_chk(OFS_OMASK, 32'h0, "R1 omask");

        // R2 free list drains in order
        for (int i = 0; i < 8; i++)
            rd_chk(OFS_INQ, 32'h1000 + 32'(i) * 32'h100, "R2 free handle");
        // R3 empty reads
        rd_chk(OFS_INQ, EMPTY_WORD, "R3 empty free list");
        rd_chk(OFS_INQ, EMPTY_WORD, "R3 empty free list again");
        // R6 return controller handle, tagged handle ignored
        host_wr(OFS_OUTQ, 32'h1300);
        host_wr(OFS_OUTQ, 32'h8000_0040);
        rd_chk(OFS_INQ, 32'h1300, "R6 returned handle");
        rd_chk(OFS_INQ, EMPTY_WORD, "R6 tagged handle not freed");
        rd_chk(OFS_OUTQ, EMPTY_WORD, "R5 empty completion queue");

        // R4 / R9 post with stub idle
        post(32'h1000);
        rd_chk(OFS_ISTAT, 32'h8, "R9 post status bit3");
        chk(irq_in, "R9 irq_in on post", {31'h0, irq_in}, 32'h1);
        chk(agent_req_valid && agent_req_handle == 32'h1000, "R4 pending head", agent_req_handle, 32'h1000);
        agent_iclr(4'hF);
        chk(!irq_in, "R9 agent clear", {31'h0, irq_in}, 32'h0);

        // R5 / R7 / R8 completion path
        stub_en = 1'b1;
        repeat (4) @(negedge clk);
        rd_chk(OFS_OSTAT, 32'h1, "R7 completion status");
        chk(irq_out, "R8 irq_out raised", {31'h0, irq_out}, 32'h1);
        host_pop("R5 completion");
        host_wr(OFS_OSTAT, 32'h1);
        rd_chk(OFS_OSTAT, 32'h0, "R7 write-one clear");
        chk(!irq_out, "R8 irq_out dropped", {31'h0, irq_out}, 32'h0);

        // R4 / R5 mixed handles with context substitution
        post(32'h8000_0041);
        post(32'h1200);
        post(32'h8001_2345);
        post(32'h8000_0100);
        repeat (10) @(negedge clk);
        for (int i = 0; i < 4; i++) host_pop("R5 ordered completion");
        rd_chk(OFS_OUTQ, EMPTY_WORD, "R5 drained");

        // R8 mask
        host_wr(OFS_OSTAT, 32'h3);
        host_wr(OFS_OMASK, 32'h1);
        post(32'h1400);
        repeat (6) @(negedge clk);
        rd_chk(OFS_OSTAT, 32'h1, "R8 status under mask");
        chk(!irq_out, "R8 masked irq", {31'h0, irq_out}, 32'h0);
        host_wr(OFS_OMASK, 32'h0);
        chk(irq_out, "R8 unmasked irq", {31'h0, irq_out}, 32'h1);
        host_pop("R5 masked completion");
        host_wr(OFS_OSTAT, 32'h1);

        // R9 messages and doorbell
        agent_iclr(4'hF);
        host_wr(OFS_IMSG0, 32'hA5A5);
        chk(agent_imsg0 == 32'hA5A5, "R9 agent_imsg0", agent_imsg0, 32'hA5A5);
        rd_chk(OFS_ISTAT, 32'h1, "R9 msg0 status");
        host_wr(OFS_IMSG1, 32'h77);
        chk(agent_imsg1 == 32'h77, "R9 agent_imsg1", agent_imsg1, 32'h77);
        host_wr(OFS_IDB, 32'h3);
        host_wr(OFS_IDB, 32'h4);
        rd_chk(OFS_IDB, 32'h7, "R9 doorbell OR");
        rd_chk(OFS_ISTAT, 32'h7, "R9 istat bits");
        host_wr(OFS_IMASK, 32'hF);
        chk(!irq_in, "R9 masked irq_in", {31'h0, irq_in}, 32'h0);
        host_wr(OFS_IMASK, 32'h0);
        chk(irq_in, "R9 unmasked irq_in", {31'h0, irq_in}, 32'h1);
        @(negedge clk); agent_db_clr = 32'h1;
        @(negedge clk); agent_db_clr = 32'h0;
        chk(agent_doorbell == 32'h6, "R9 doorbell clear", agent_doorbell, 32'h6);
        agent_iclr(4'hF);
        chk(!irq_in, "R9 cleared irq_in", {31'h0, irq_in}, 32'h0);

        // R11 outbound message echo
        agent_omsg(1'b0, 32'hA5A5);
        rd_chk(OFS_OMSG0, 32'hA5A5, "R11 omsg0 echo");
        rd_chk(OFS_OSTAT, 32'h2, "R7 omsg status");
        host_wr(OFS_OMSG0, 32'h1234);
        rd_chk(OFS_OMSG0, 32'hA5A5, "R11 host write ignored");
        agent_omsg(1'b1, 32'h99);
        rd_chk(OFS_OMSG1, 32'h99, "R11 omsg1");
        host_wr(OFS_OSTAT, 32'h3);

        // R10 pending full drops a post
        stub_en = 1'b0;
        for (int i = 0; i < 4; i++) post(32'h8000_0200 + 32'(i) * 32'h2);
        host_wr(OFS_INQ, 32'h8000_0300);
        stub_en = 1'b1;
        repeat (10) @(negedge clk);
        chk(!agent_req_valid, "R10 dropped post", {31'h0, agent_req_valid}, 32'h0);
        for (int i = 0; i < 4; i++) host_pop("R10 kept posts");
        rd_chk(OFS_OUTQ, EMPTY_WORD, "R10 nothing extra");

        // R10 completion full stalls the agent
        for (int i = 0; i < 5; i++) post(32'h1000 + 32'(i) * 32'h100);
        repeat (20) @(negedge clk);
        chk(!agent_cpl_ready, "R10 cpl full", {31'h0, agent_cpl_ready}, 32'h0);
        chk(agent_req_valid && agent_req_handle == 32'h1400, "R10 request held", agent_req_handle, 32'h1400);
        host_pop("R10 drain first");
        repeat (4) @(negedge clk);
        for (int i = 0; i < 4; i++) host_pop("R10 drain rest");
        rd_chk(OFS_OUTQ, EMPTY_WORD, "R10 drained");

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule